// File: doc/BRIEF.md
# Modem Mode Control and Interrupt Logic

This block holds the 8-bit operating-mode byte of a packet data modem and derives from it every control that the rest of the modem reads: the transmit/receive select, the data inversion control, the converter power enables and the scrambler gating. It also collects the interrupt sources, which are the arrival of a new data-quality reading and the loss of synthesiser lock, into sticky status bits. From those bits it drives an active-low interrupt pin.

Writing the mode byte has side effects. Flipping the direction bit while a task is running produces a one-cycle cancel pulse. A receive-to-transmit change holds a ready flag low for two bit-period ticks so that the transmit filter settles before a new task starts. The scrambler is held in reset unless scrambling is enabled and the current task is one of the five data-block or training-sequence tasks. The host clears the status bits with a single clear pulse.

Top module: `modem_mode_ctrl`

## Requirements
- R1: After reset the mode byte is 0x00. In that state `irq_no` is 1, all status bits and `task_cancel_o` are 0, `tx_sel_o`, `data_inv_o`, `adc_en_o`, `dac_en_o` and `scr_en_o` are 0, and `scr_rst_o` and `task_ready_o` are 1.
- R2: A write stores `wr_data_i` on the clock edge. From then on, bit6 drives `data_inv_o`, bit5 drives `tx_sel_o` (1 = transmit), bit1 drives `adc_en_o` and bit0 drives `dac_en_o`. Without a write the byte is unchanged.
- R3: `irq_no` is 0 exactly when `stat_irq_o` is 1 and mode bit7 is 1. Otherwise it is 1.
- R4: A write that changes bit5 while `task_busy_i` is 1 makes `task_cancel_o` 1 for the single cycle after that edge. Any other write, and any cycle without a write, leaves `task_cancel_o` at 0.
- R5: A write that changes bit5 from 0 to 1 drops `task_ready_o` after that edge. The flag stays 0 until two `bit_tick_i` pulses have been sampled on later edges. A write that changes bit5 from 1 to 0 restores `task_ready_o` to 1 at once. A write that keeps bit5 as it was leaves the count unchanged.
- R6: `scr_en_o` is 1 only when mode bit4 is 1 and `task_code_i` is one of 0x3, 0x4, 0x5, 0x9 or 0xA. `scr_rst_o` is always the inverse of `scr_en_o`.
- R7: When mode bit3 is 1, a `lock_lost_i` pulse sets both `stat_lock_lost_o` and `stat_irq_o` on that edge. When bit3 is 0, the pulse has no effect.
- R8: In receive mode (bit5 = 0) with bit2 = 1, a `dq_new_i` pulse sets both `stat_dqrdy_o` and `stat_irq_o`. In transmit mode, or with bit2 = 0, the pulse has no effect.
- R9: The status bits stay set until a `stat_clr_i` pulse clears them. A new event in the same cycle as a clear wins, and its bits stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the mode byte |
| wr_data_i | input | 8 | Mode byte to write |
| task_code_i | input | 4 | Code of the current modem task |
| task_busy_i | input | 1 | A task is running |
| bit_tick_i | input | 1 | One pulse per bit period |
| dq_new_i | input | 1 | A new data-quality reading is ready |
| lock_lost_i | input | 1 | Synthesiser lock-lost event |
| stat_clr_i | input | 1 | Clears the status bits |
| irq_no | output | 1 | Interrupt pin, active low |
| stat_irq_o | output | 1 | Status: interrupt pending |
| stat_dqrdy_o | output | 1 | Status: data-quality reading ready |
| stat_lock_lost_o | output | 1 | Status: lock lost |
| task_cancel_o | output | 1 | One-cycle task cancel pulse |
| scr_en_o | output | 1 | Scrambler enable |
| scr_rst_o | output | 1 | Scrambler held in reset |
| data_inv_o | output | 1 | Invert data (swap I and Q) |
| tx_sel_o | output | 1 | 1 = transmit, 0 = receive |
| adc_en_o | output | 1 | Main ADC power enable |
| dac_en_o | output | 1 | Main DAC power enable |
| task_ready_o | output | 1 | A new task may start |

## Verification
The mode fields, status bits, cancel pulse and ready flag all change one edge after the input that causes them. `irq_no` follows a status or mode change through combinational logic in that same cycle. `scr_en_o` and `scr_rst_o` follow `task_code_i` with no register in between. The bench drives inputs on the falling edge and steps a behavioural model on the rising edge. It compares every output on the next falling edge, so each registered result is checked in the cycle after its cause and each combinational one in the cycle of its cause.

// File: rtl/modem_mode_pkg.sv
package modem_mode_pkg;
  localparam int unsigned MODE_W = 8;
  localparam int unsigned TASK_W = 4;

  typedef struct packed {
    logic irq_pin_en;   // bit7
    logic inv;          // bit6
    logic tx;           // bit5
    logic scr_en;       // bit4
    logic lock_irq_en;  // bit3
    logic dq_irq_en;    // bit2
    logic adc_en;       // bit1
    logic dac_en;       // bit0
  } mode_t;

  localparam int unsigned N_SCR_TASKS = 5;
  localparam logic [N_SCR_TASKS*TASK_W-1:0] SCR_TASKS =
    {4'h3, 4'h4, 4'h5, 4'h9, 4'hA};
endpackage

// File: rtl/modem_mode_reg.sv
module modem_mode_reg
  import modem_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [MODE_W-1:0] wr_data_i,
  input  logic              task_busy_i,
  output mode_t             mode_o,
  output logic              to_tx_o,
  output logic              to_rx_o,
  output logic              cancel_o
);
  mode_t mode_q, mode_d;
  logic  dir_flip;

  assign mode_d   = mode_t'(wr_data_i);
  assign dir_flip = wr_en_i && (mode_d.tx != mode_q.tx);
  assign to_tx_o  = dir_flip && mode_d.tx;
  assign to_rx_o  = dir_flip && !mode_d.tx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      cancel_o <= 1'b0;
    end else begin
      if (wr_en_i) mode_q <= mode_d;
      cancel_o <= dir_flip && task_busy_i;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/modem_settle_timer.sv
module modem_settle_timer #(
  parameter int unsigned SETTLE_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_TICKS + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (arm_i)                  cnt_q <= CNT_W'(SETTLE_TICKS);
    else if (clear_i)                cnt_q <= '0;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/modem_irq_status.sv
module modem_irq_status
  import modem_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_t mode_i,
  input  logic  dq_new_i,
  input  logic  lock_lost_i,
  input  logic  clr_i,
  output logic  irq_o,
  output logic  dqrdy_o,
  output logic  lock_o,
  output logic  pin_no
);
  logic dq_set, lock_set;

  // data-quality source is masked in transmit
  assign dq_set   = dq_new_i && mode_i.dq_irq_en && !mode_i.tx;
  assign lock_set = lock_lost_i && mode_i.lock_irq_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o   <= 1'b0;
      dqrdy_o <= 1'b0;
      lock_o  <= 1'b0;
    end else begin
      irq_o   <= dq_set || lock_set || (irq_o && !clr_i);
      dqrdy_o <= dq_set || (dqrdy_o && !clr_i);
      lock_o  <= lock_set || (lock_o && !clr_i);
    end
  end

  assign pin_no = !(irq_o && mode_i.irq_pin_en);
endmodule

// File: rtl/modem_scr_gate.sv
module modem_scr_gate
  import modem_mode_pkg::*;
(
  input  logic              scr_bit_i,
  input  logic [TASK_W-1:0] task_code_i,
  output logic              scr_en_o,
  output logic              scr_rst_o
);
  logic [N_SCR_TASKS-1:0] hit;

  for (genvar g = 0; g < N_SCR_TASKS; g++) begin : g_match
    assign hit[g] = (task_code_i == SCR_TASKS[g*TASK_W +: TASK_W]);
  end

  assign scr_en_o  = scr_bit_i && (|hit);
  assign scr_rst_o = !scr_en_o;
endmodule

// File: rtl/modem_mode_ctrl.sv
module modem_mode_ctrl
  import modem_mode_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [MODE_W-1:0] wr_data_i,
  input  logic [TASK_W-1:0] task_code_i,
  input  logic              task_busy_i,
  input  logic              bit_tick_i,
  input  logic              dq_new_i,
  input  logic              lock_lost_i,
  input  logic              stat_clr_i,
  output logic              irq_no,
  output logic              stat_irq_o,
  output logic              stat_dqrdy_o,
  output logic              stat_lock_lost_o,
  output logic              task_cancel_o,
  output logic              scr_en_o,
  output logic              scr_rst_o,
  output logic              data_inv_o,
  output logic              tx_sel_o,
  output logic              adc_en_o,
  output logic              dac_en_o,
  output logic              task_ready_o
);
  mode_t mode;
  logic  to_tx, to_rx;

  modem_mode_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .task_busy_i,
    .mode_o(mode), .to_tx_o(to_tx), .to_rx_o(to_rx), .cancel_o(task_cancel_o)
  );

  modem_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk_i, .rst_ni, .arm_i(to_tx), .clear_i(to_rx),
    .tick_i(bit_tick_i), .ready_o(task_ready_o)
  );

  modem_irq_status u_irq (
    .clk_i, .rst_ni, .mode_i(mode), .dq_new_i, .lock_lost_i, .clr_i(stat_clr_i),
    .irq_o(stat_irq_o), .dqrdy_o(stat_dqrdy_o), .lock_o(stat_lock_lost_o),
    .pin_no(irq_no)
  );

  modem_scr_gate u_scr (
    .scr_bit_i(mode.scr_en), .task_code_i, .scr_en_o, .scr_rst_o
  );

  assign data_inv_o = mode.inv;
  assign tx_sel_o   = mode.tx;
  assign adc_en_o   = mode.adc_en;
  assign dac_en_o   = mode.dac_en;
endmodule

// File: rtl/modem_mode_chk.sv
module modem_mode_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic task_busy_i,
  input logic stat_clr_i,
  input logic irq_no,
  input logic stat_irq_o,
  input logic stat_dqrdy_o,
  input logic stat_lock_lost_o,
  input logic task_cancel_o,
  input logic tx_sel_o,
  input logic task_ready_o
);
  // R3
  pin_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> stat_irq_o);
  // R4
  cancel_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_cancel_o |-> $past(task_busy_i));
  // R4
  cancel_needs_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_cancel_o |-> (tx_sel_o != $past(tx_sel_o)));
  // R5
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_sel_o) |-> !task_ready_o);
  // R8
  dq_rx_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_dqrdy_o) |-> !$past(tx_sel_o));
  // R9
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_irq_o) |-> $past(stat_clr_i));
  // R9
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_lock_lost_o) |-> $past(stat_clr_i));
endmodule

bind modem_mode_ctrl modem_mode_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .task_busy_i(task_busy_i), .stat_clr_i(stat_clr_i),
  .irq_no(irq_no), .stat_irq_o(stat_irq_o), .stat_dqrdy_o(stat_dqrdy_o),
  .stat_lock_lost_o(stat_lock_lost_o), .task_cancel_o(task_cancel_o),
  .tx_sel_o(tx_sel_o), .task_ready_o(task_ready_o)
);

// File: tb/modem_mode_ctrl_bench.sv
module modem_mode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] task_code = '0;
  logic       busy = 1'b0, tick = 1'b0, dq = 1'b0, lk = 1'b0, clr = 1'b0;
  logic irq_n, s_irq, s_dq, s_lk, cancel, scr_en, scr_rst, inv, tx, adc, dac, ready;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  modem_mode_ctrl u_modem_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .task_code_i(task_code), .task_busy_i(busy), .bit_tick_i(tick),
    .dq_new_i(dq), .lock_lost_i(lk), .stat_clr_i(clr),
    .irq_no(irq_n), .stat_irq_o(s_irq), .stat_dqrdy_o(s_dq),
    .stat_lock_lost_o(s_lk), .task_cancel_o(cancel), .scr_en_o(scr_en),
    .scr_rst_o(scr_rst), .data_inv_o(inv), .tx_sel_o(tx), .adc_en_o(adc),
    .dac_en_o(dac), .task_ready_o(ready)
  );

  // behavioural reference
  logic [7:0] m_mode = '0;
  int         m_ticks = 0;
  logic       m_irq = 0, m_dq = 0, m_lk = 0, m_cancel = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= '0; m_ticks <= 0; m_irq <= 0; m_dq <= 0; m_lk <= 0; m_cancel <= 0;
    end else begin
      automatic bit flip = wr_en && (wr_data[5] != m_mode[5]);
      automatic bit dset = dq && m_mode[2] && !m_mode[5];
      automatic bit lset = lk && m_mode[3];
      m_cancel <= flip && busy;
      if (flip && wr_data[5])      m_ticks <= 2;
      else if (flip)               m_ticks <= 0;
      else if (tick && m_ticks > 0) m_ticks <= m_ticks - 1;
      m_dq  <= dset || (m_dq && !clr);
      m_lk  <= lset || (m_lk && !clr);
      m_irq <= dset || lset || (m_irq && !clr);
      if (wr_en) m_mode <= wr_data;
    end
  end

  task automatic chk(input bit act, input bit exp, input string req);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  function automatic bit scr_task(input logic [3:0] c);
    return c == 4'h3 || c == 4'h4 || c == 4'h5 || c == 4'h9 || c == 4'hA;
  endfunction

  // compare all outputs on every falling edge, before new stimulus
  always @(negedge clk) if (rst_n) begin
    chk(inv,   m_mode[6], "R2 data_inv");
    chk(tx,    m_mode[5], "R2 tx_sel");
    chk(adc,   m_mode[1], "R2 adc_en");
    chk(dac,   m_mode[0], "R2 dac_en");
    chk(irq_n, !(m_irq && m_mode[7]), "R3 irq pin");
    chk(cancel, m_cancel, "R4 cancel");
    chk(ready, m_ticks == 0, "R5 ready");
    chk(scr_en, m_mode[4] && scr_task(task_code), "R6 scr_en");
    chk(scr_rst, !(m_mode[4] && scr_task(task_code)), "R6 scr_rst");
    chk(s_lk,  m_lk,  "R7 lock status");
    chk(s_dq,  m_dq,  "R8 dqrdy status");
    chk(s_irq, m_irq, "R9 irq status");
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
    #1;
    wr_en = 0; tick = 0; dq = 0; lk = 0; clr = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; step();
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #10;
    // R1 reset state
    chk(irq_n, 1, "R1 irq_no"); chk(s_irq, 0, "R1 stat_irq");
    chk(tx, 0, "R1 tx_sel");    chk(ready, 1, "R1 ready");
    chk(scr_rst, 1, "R1 scr_rst"); chk(adc, 0, "R1 adc_en");
    rst_n = 1;
    step(2);
    wr(8'h43);                          // R2 inv, adc, dac
    wr(8'h84); dq = 1; step();          // R8 dq in rx
    step(2);
    clr = 1; step();                    // R9 clear
    dq = 1; clr = 1; step();            // R9 set wins
    clr = 1; step();
    busy = 1; wr(8'hA4);                // R4 cancel, R5 settle
    dq = 1; step();                     // R8 ignored in tx
    tick = 1; step(); step(2); tick = 1; step(); step();
    lk = 1; step();                     // R7 bit3 clear: no effect
    wr(8'hAC); lk = 1; step(); step();  // R7 enabled
    wr(8'h2C); step();                  // R3 pin masked
    busy = 1; wr(8'h0C); tick = 1; step(); // R5 tx->rx restores ready
    wr(8'h0C);                           // R4 no flip no cancel
    busy = 0;
    wr(8'h10);
    for (int c = 0; c < 16; c++) begin task_code = 4'(c); step(); end  // R6
    wr(8'h30);
    for (int c = 0; c < 16; c++) begin task_code = 4'(c); step(); end
    for (int i = 0; i < 600; i++) begin
      wr_en = ($urandom_range(0, 7) == 0); wr_data = 8'($urandom);
      busy = $urandom_range(0, 1); tick = $urandom_range(0, 1);
      dq = $urandom_range(0, 1); lk = ($urandom_range(0, 3) == 0);
      clr = ($urandom_range(0, 5) == 0); task_code = 4'($urandom);
      @(negedge clk); #1;
    end
    step(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule